// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a small memory-mapped tick timer for a processor subsystem. Software programs a period, selects whether the counter steps on every bus clock or only on a reference-clock strobe, and enables it. The counter then runs down to zero, wraps back to the programmed period, raises a sticky wrap indicator and, if asked, emits a one-cycle interrupt pulse. Typical use is a fixed operating-system heartbeat: software writes the period, writes the current-value register to restart the count cleanly, then enables with the interrupt bit set.

The register port is a plain single-cycle bus: `bus_valid` qualifies an access, `bus_write` selects direction, and read data appears registered on `bus_rdata` one cycle after the read request. Only aligned 32-bit words are decoded. The reference clock is not generated here. It comes in as a one-cycle enable strobe that is synchronous to `clk`.

Top module: `tick_timer`

## Requirements
- R1: Register word offsets are control/status 0x0, period 0x4, current count 0x8 and calibration 0xC. Calibration always reads 10000 (decimal). Any other offset reads 0 and ignores writes. This includes offsets at or above 0x10 and offsets with address bits 1:0 not zero.
- R2: Control bit 0 is run enable, bit 1 is interrupt enable, bit 2 selects the reference strobe (1) or the bus clock (0), and bit 16 is the sticky wrap flag. A control write updates only bits 2:0, leaves the wrap flag unchanged, and the other bits always read 0.
- R3: A read of the control/status register returns the flag value held before the read, and the flag is 0 after that read.
- R4: A write that takes run enable from 0 to 1 loads the period into the counter. With the bus clock selected, the first wrap then happens period+1 cycles later, and each following wrap comes period+1 cycles after the previous one. While run enable is 0, the count holds its value.
- R5: A wrap (counter stepping while at 0) sets the wrap flag. If interrupt enable is 1, the wrap also drives `irq` high for exactly one cycle, in the cycle after the wrap step. If interrupt enable is 0, `irq` stays low.
- R6: A write of any data to the current-count register loads the period into the counter and clears the wrap flag. A step or wrap that would fall in the same cycle is cancelled.
- R7: If the period is 0 when a wrap occurs, run enable clears to 0 and counting stops.
- R8: When bit 2 is 1, the counter steps only in cycles where `ref_tick` is 1.
- R9: A control write that flips bit 2 while leaving run enable unchanged loads the period into the counter.
- R10: After reset, control, period and current count all read 0, and `irq` is low.
- R11: The period and count are CNT_W bits wide (24 by default). Period writes keep the low CNT_W bits, and the upper bits of both registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| ref_tick | input | 1 | One-cycle reference-clock enable strobe |
| irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
The embedded properties assume that `bus_valid` is low during reset. They also assume that `ref_tick` is a clean synchronous level sampled on the rising edge. The period-cadence property also depends on no reload being requested in the same cycle as a step, unless the load is meant to win. The bench drives every bus access and every reference strobe on the falling edge and holds each one for exactly one rising edge, so each access is seen once and never overlaps reset. Period sweeps use small periods (0 to 8 and 20), and the bench predicts every wrap edge arithmetically from the cycle of the enabling write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // word index of each register (byte offset >> 2)
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_PER  = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
  localparam logic [1:0] IDX_CAL  = 2'd3;

  // control/status bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_IEN  = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef struct packed {
    logic src_ref;
    logic irq_en;
    logic run;
  } ctl_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PER,
    SEL_CNT,
    SEL_CAL
  } reg_sel_e;

endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output reg_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_per,
  output logic              wr_cnt,
  output logic              rd_ctrl
);

  logic hi_zero;

  generate
    if (ADDR_W > 4) begin : g_hi
      assign hi_zero = (acc_addr[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (hi_zero && acc_addr[1:0] == 2'b00) begin
      unique case (acc_addr[3:2])
        IDX_CTRL: sel = SEL_CTRL;
        IDX_PER:  sel = SEL_PER;
        IDX_CNT:  sel = SEL_CNT;
        default:  sel = SEL_CAL;
      endcase
    end
  end

  assign wr_ctrl = acc_valid &  acc_write & (sel == SEL_CTRL);
  assign wr_per  = acc_valid &  acc_write & (sel == SEL_PER);
  assign wr_cnt  = acc_valid &  acc_write & (sel == SEL_CNT);
  assign rd_ctrl = acc_valid & ~acc_write & (sel == SEL_CTRL);

  // at most one write strobe per access
  always_comb begin
    AST_ONE_WRITE_STROBE: assert ($countones({wr_ctrl, wr_per, wr_cnt}) <= 1); // R1
  end

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_per,
  input  logic             wr_cnt,
  input  logic             rd_ctrl,
  input  logic [CNT_W-1:0] wdata,
  input  logic             wrap,
  output ctl_t             ctl,
  output logic             flag,
  output logic [CNT_W-1:0] period,
  output logic             load_req
);

  logic run_rise;
  logic src_flip;

  assign run_rise = wr_ctrl & wdata[BIT_RUN] & ~ctl.run;
  assign src_flip = wr_ctrl & (wdata[BIT_RUN] == ctl.run) & (wdata[BIT_SRC] != ctl.src_ref);
  assign load_req = wr_cnt | run_rise | src_flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (wr_ctrl) begin
      ctl.run     <= wdata[BIT_RUN];
      ctl.irq_en  <= wdata[BIT_IEN];
      ctl.src_ref <= wdata[BIT_SRC];
    end else if (wrap && period == '0) begin
      ctl.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (wrap) begin
      flag <= 1'b1;
    end else if (wr_cnt || rd_ctrl) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
    end else if (wr_per) begin
      period <= wdata;
    end
  end

  AST_ZERO_PERIOD_STOPS: assert property (@(posedge clk) disable iff (rst)
    wrap && period == '0 && !wr_ctrl |=> !ctl.run); // R7

  AST_FLAG_KEPT_ON_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && !wrap |=> flag == $past(flag)); // R2

  AST_FLAG_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl && !wrap |=> !flag); // R3

  AST_FLAG_CLEARED_BY_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> !flag); // R6

endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_ref,
  input  logic             irq_en,
  input  logic             ref_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             irq
);

  logic step;
  logic at_zero;

  assign step    = run & (src_ref ? ref_tick : 1'b1) & ~load;
  assign at_zero = (count == '0);
  assign wrap    = step & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= period;
    end else if (step) begin
      count <= at_zero ? period : count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= wrap & irq_en;
  end

  AST_LOAD_TAKES_PERIOD: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(period)); // R6

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    run && !src_ref && !load && count != '0 |=> count == $past(count) - 1'b1); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run && !load |=> $stable(count)); // R4

  AST_REF_WAIT: assert property (@(posedge clk) disable iff (rst)
    run && src_ref && !ref_tick && !load |=> $stable(count)); // R8

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  output logic              irq
);

  reg_sel_e         sel;
  logic             wr_ctrl, wr_per, wr_cnt, rd_ctrl;
  ctl_t             ctl;
  logic             flag;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] count;
  logic             load_req;
  logic             wrap;
  logic [31:0]      rd_mux;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:CNT_W];

  tick_timer_decode #(.ADDR_W(ADDR_W)) u_decode (
    .acc_valid (bus_valid),
    .acc_write (bus_write),
    .acc_addr  (bus_addr),
    .sel       (sel),
    .wr_ctrl   (wr_ctrl),
    .wr_per    (wr_per),
    .wr_cnt    (wr_cnt),
    .rd_ctrl   (rd_ctrl)
  );

  tick_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_per   (wr_per),
    .wr_cnt   (wr_cnt),
    .rd_ctrl  (rd_ctrl),
    .wdata    (bus_wdata[CNT_W-1:0]),
    .wrap     (wrap),
    .ctl      (ctl),
    .flag     (flag),
    .period   (period),
    .load_req (load_req)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .run      (ctl.run),
    .src_ref  (ctl.src_ref),
    .irq_en   (ctl.irq_en),
    .ref_tick (ref_tick),
    .load     (load_req),
    .period   (period),
    .count    (count),
    .wrap     (wrap),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_mux[BIT_RUN]  = ctl.run;
        rd_mux[BIT_IEN]  = ctl.irq_en;
        rd_mux[BIT_SRC]  = ctl.src_ref;
        rd_mux[BIT_FLAG] = flag;
      end
      SEL_PER:  rd_mux = 32'(period);
      SEL_CNT:  rd_mux = 32'(count);
      SEL_CAL:  rd_mux = 32'(CAL_VALUE);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_valid && !bus_write) begin
      bus_rdata <= rd_mux;
    end
  end

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R5

  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_write && sel == SEL_CTRL
      |=> bus_rdata[31:17] == '0 && bus_rdata[15:3] == '0); // R2

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_write && sel == SEL_NONE |=> bus_rdata == '0); // R1

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_valid;
  logic              bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              ref_tick;
  logic              irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  tick_timer #(.ADDR_W(ADDR_W), .CNT_W(24), .CAL_VALUE(10000)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ref_tick  (ref_tick),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // each access is held for exactly one rising edge; returns at the next falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ref_pulse();
    ref_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hit1, hit2, hits;

    rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0; ref_tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check("R10 irq low", {31'b0, irq}, 32'h0);
    rd(8'h00, v); check("R10 ctrl reset", v, 32'h0);
    rd(8'h04, v); check("R10 period reset", v, 32'h0);
    rd(8'h08, v); check("R10 count reset", v, 32'h0);
    // R1: calibration constant
    rd(8'h0C, v); check("R1 calibration", v, 32'd10000);

    // R11: period width
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R11 period upper bits zero", v, 32'h00FF_FFFF);

    // R2: only bits 2:0 writable
    wr(8'h00, 32'hFFFF_FFF8);
    rd(8'h00, v); check("R2 upper ctrl bits ignored", v, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 ctrl low bits", v, 32'h7);
    wr(8'h00, 32'h0);

    // R1: unmapped and misaligned offsets
    wr(8'h10, 32'h7);
    wr(8'h06, 32'h5);
    rd(8'h00, v); check("R1 write to 0x10 ignored", v, 32'h0);
    rd(8'h04, v); check("R1 misaligned write ignored", v, 32'h00FF_FFFF);
    rd(8'h10, v); check("R1 unmapped read 0x10", v, 32'h0);
    rd(8'h05, v); check("R1 misaligned read", v, 32'h0);
    rd(8'hFC, v); check("R1 unmapped read 0xFC", v, 32'h0);

    // R4 R5 R3 R2: period sweep on the bus clock
    for (int r = 1; r <= 8; r++) begin
      wr(8'h04, r);
      wr(8'h00, 32'h3);
      hit1 = 0; hit2 = 0; hits = 0;
      for (int k = 1; k <= 2 * (r + 1) + 1; k++) begin
        @(posedge clk); @(negedge clk);
        if (irq) begin
          hits++;
          if (hit1 == 0) hit1 = k; else if (hit2 == 0) hit2 = k;
        end
      end
      check("R4 first wrap after period+1", hit1, r + 1);
      check("R4 second wrap spacing", hit2, 2 * (r + 1));
      check("R5 irq pulses one cycle each", hits, 2);
      wr(8'h00, 32'h0);
      rd(8'h00, v); check("R2 flag kept across ctrl write", v, 32'h0001_0000);
      rd(8'h00, v); check("R3 flag cleared by read", v, 32'h0);
    end

    // R5: no irq when interrupt enable is 0, flag still set
    wr(8'h04, 32'd4);
    wr(8'h00, 32'h1);
    hits = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); @(negedge clk);
      if (irq) hits++;
    end
    check("R5 no irq when disabled", hits, 0);
    wr(8'h00, 32'h0);
    rd(8'h00, v); check("R5 flag set without irq", v, 32'h0001_0000);

    // R6: count write reloads and clears flag
    wr(8'h04, 32'd3);
    wr(8'h00, 32'h1);      // E0: count=3
    idle(6);               // wrap at E4, count 0 after E7
    wr(8'h04, 32'd20);     // E7
    wr(8'h08, 32'hDEAD);   // E8: load wins over wrap
    rd(8'h08, v); check("R6 count reloaded", v, 32'd20);
    rd(8'h00, v); check("R6 flag cleared by count write", v, 32'h1);
    // R4: hold while disabled (count 17 after disabling edge)
    wr(8'h00, 32'h0);
    rd(8'h08, v); check("R4 hold value", v, 32'd17);
    idle(4);
    rd(8'h08, v); check("R4 hold stable", v, 32'd17);

    // R8 R9: reference strobe source and source switch
    wr(8'h04, 32'd10);
    wr(8'h00, 32'h5);
    idle(5);
    rd(8'h08, v); check("R8 no steps without strobe", v, 32'd10);
    ref_pulse(); idle(2); ref_pulse(); ref_pulse();
    rd(8'h08, v); check("R8 one step per strobe", v, 32'd7);
    wr(8'h00, 32'h1);
    rd(8'h08, v); check("R9 source flip reloads", v, 32'd10);
    wr(8'h00, 32'h0);

    // R7: zero period stops after one wrap
    wr(8'h04, 32'd0);
    wr(8'h00, 32'h3);
    hit1 = 0; hits = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin hits++; if (hit1 == 0) hit1 = k; end
    end
    check("R7 single wrap at once", hit1, 1);
    check("R7 only one wrap", hits, 1);
    rd(8'h00, v); check("R7 run cleared, flag set", v, 32'h0001_0002);
    wr(8'h00, 32'h1);
    idle(3);
    wr(8'h00, 32'h0001_0000);
    rd(8'h00, v); check("R2 flag bit not writable", v, 32'h0001_0000);
    rd(8'h00, v); check("R3 second read clear", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule